// File: doc/BRIEF.md
# Receive Control-Character Checker for a 10G Media-Independent Bus

The block watches the receive side of a 64-bit, eight-lane 10G media-independent bus. It sits beside the reconciliation logic. Each lane carries a byte and a control flag. The two 32-bit half-words that arrive on the two clock edges are assumed to be already merged into one 64-bit word per clock. From the Start and Terminate control characters the block works out where frames begin and end. It keeps three saturating counters:

- frames that contain error symbols signalled by the PHY;
- framing faults on the data path, such as a Start in a lane where it is not allowed, a missing start-frame delimiter, or the wrong control character inside a frame;
- stray control characters that appear between frames.

The input is a stream qualified by `in_valid`. The block is a passive monitor, so it never applies back-pressure and has no ready signal. A word counts only in a cycle where `in_valid` is high. While `in_valid` is low, all tracking state and all counters hold. Each counter shows the effect of a word on the clock edge that accepts it, so the new value can be read in the following cycle.

Top module: `xrx_ctrl_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all three counters to zero and leaves the block outside any frame with no delimiter check pending.
- R2: A Start in any lane other than 0 or 4 adds one to the data-error counter and does not open a frame. If a frame was open, that frame is closed.
- R3: For a Start in lane 0, lane 7 of the same word must carry the delimiter as a data byte. For a Start in lane 4, lane 3 of the next valid word must carry it. Each miss adds one to the data-error counter.
- R4: A legal Start that arrives while a frame is open adds one to the data-error counter and opens a new frame. The new frame's symbol-error allowance is fresh.
- R5: Inside a frame, an Idle control character adds one data error and closes the frame. Any control code other than Start, Terminate, Error or Idle adds one data error and leaves the frame open.
- R6: An Error control character from the Start lane through the Terminate lane adds one to the symbol-error counter. This happens at most once per frame. A single word can complete at most three frames' worth of such increments.
- R7: Outside a frame, each Terminate, each Error and each unknown control code adds one to the control-error counter. Idle and data bytes there have no effect.
- R8: Counters only ever rise between resets. All events in one word add together, and the sum is visible in the cycle after the word is accepted.
- R9: A cycle with `in_valid` low changes no counter and no frame state.
- R10: A counter that reaches its maximum value (all ones, `CNT_W` bits) stays there.
- R11: Lane i occupies `rx_data[8i+7:8i]` with control flag `rx_ctrl[i]`, and lanes are evaluated from 0 upward. The codes are Idle 0x07, Start 0xFB, Terminate 0xFD and Error 0xFE, each with its flag set. The delimiter is 0xD5 with its flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The word on `rx_data`/`rx_ctrl` is valid this cycle |
| rx_data | input | 64 | Eight lane bytes, lane 0 in the low byte |
| rx_ctrl | input | 8 | Per-lane control flag |
| sym_err_count | output | CNT_W | Frames that contained error symbols |
| data_err_count | output | CNT_W | Framing errors on the data path |
| ctrl_err_count | output | CNT_W | Control characters outside frames |

## Verification
The only internal state is the open-frame flag, the per-frame error-seen flag and the pending delimiter check, and each of them shows up at the counters within one or two words. If the open-frame flag is wrong, the next Terminate or Error lands in the control-error counter when it should not, or is missed when it should land there. If the error-seen flag is wrong, a second Error in the same frame is counted twice, or the first Error of a new frame is lost. If a lane-4 Start loses its pending check, a bad delimiter in the next word goes uncounted, and a stale pending check charges an error to a clean word. The bench compares all three counters against its model on every cycle, so any of these faults shows up one cycle after the word that exposes it.

// File: rtl/xrx_chk_pkg.sv
`timescale 1ns/1ps
package xrx_chk_pkg;
  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_ERR   = 8'hFE;
  localparam logic [7:0] CH_SFD   = 8'hD5;

  typedef enum logic [2:0] {
    LK_DATA, LK_IDLE, LK_START, LK_TERM, LK_ERR, LK_OTHER
  } lane_kind_e;

  typedef struct packed {
    lane_kind_e kind;
    logic       sfd;   // data byte equal to the start-frame delimiter
  } lane_info_t;
endpackage

// File: rtl/xrx_lane_decode.sv
`timescale 1ns/1ps
module xrx_lane_decode
  import xrx_chk_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [8*LANES-1:0]       rx_data,
  input  logic [LANES-1:0]         rx_ctrl,
  output lane_info_t [LANES-1:0]   info
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_v;
    assign byte_v = rx_data[8*g +: 8];
    always_comb begin
      info[g].sfd = !rx_ctrl[g] && (byte_v == CH_SFD);
      if (!rx_ctrl[g])               info[g].kind = LK_DATA;
      else if (byte_v == CH_IDLE)    info[g].kind = LK_IDLE;
      else if (byte_v == CH_START)   info[g].kind = LK_START;
      else if (byte_v == CH_TERM)    info[g].kind = LK_TERM;
      else if (byte_v == CH_ERR)     info[g].kind = LK_ERR;
      else                           info[g].kind = LK_OTHER;
    end
  end
endmodule

// File: rtl/xrx_frame_scan.sv
`timescale 1ns/1ps
module xrx_frame_scan
  import xrx_chk_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int SFD_OFFSET = 7,
  parameter int INC_W      = 5,
  localparam int LW        = $clog2(LANES)
) (
  input  lane_info_t [LANES-1:0] info,
  input  logic                   in_frame_q,
  input  logic                   seen_err_q,
  input  logic                   sfd_pend_q,
  input  logic [LW-1:0]          sfd_lane_q,
  output logic                   in_frame_d,
  output logic                   seen_err_d,
  output logic                   sfd_pend_d,
  output logic [LW-1:0]          sfd_lane_d,
  output logic [INC_W-1:0]       sym_inc,
  output logic [INC_W-1:0]       data_inc,
  output logic [INC_W-1:0]       ctrl_inc
);
  // Lanes are walked in order; frame state ripples from lane to lane.
  always_comb begin
    in_frame_d = in_frame_q;
    seen_err_d = seen_err_q;
    sfd_pend_d = 1'b0;
    sfd_lane_d = '0;
    sym_inc    = '0;
    data_inc   = '0;
    ctrl_inc   = '0;
    if (sfd_pend_q && !info[sfd_lane_q].sfd) data_inc = data_inc + INC_W'(1);
    for (int i = 0; i < LANES; i++) begin
      case (info[i].kind)
        LK_START: begin
          if (i == 0 || i == LANES/2) begin
            if (in_frame_d) data_inc = data_inc + INC_W'(1);
            in_frame_d = 1'b1;
            seen_err_d = 1'b0;
            if (i + SFD_OFFSET < LANES) begin
              if (!info[LW'((i + SFD_OFFSET) % LANES)].sfd)
                data_inc = data_inc + INC_W'(1);
            end else begin
              sfd_pend_d = 1'b1;
              sfd_lane_d = LW'((i + SFD_OFFSET) % LANES);
            end
          end else begin
            data_inc   = data_inc + INC_W'(1);
            in_frame_d = 1'b0;
          end
        end
        LK_TERM: begin
          if (in_frame_d) in_frame_d = 1'b0;
          else            ctrl_inc   = ctrl_inc + INC_W'(1);
        end
        LK_ERR: begin
          if (in_frame_d) begin
            if (!seen_err_d) begin
              sym_inc    = sym_inc + INC_W'(1);
              seen_err_d = 1'b1;
            end
          end else begin
            ctrl_inc = ctrl_inc + INC_W'(1);
          end
        end
        LK_IDLE: begin
          if (in_frame_d) begin
            data_inc   = data_inc + INC_W'(1);
            in_frame_d = 1'b0;
          end
        end
        LK_OTHER: begin
          if (in_frame_d) data_inc = data_inc + INC_W'(1);
          else            ctrl_inc = ctrl_inc + INC_W'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xrx_sat_counter.sv
`timescale 1ns/1ps
module xrx_sat_counter #(
  parameter int CNT_W = 64,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, count} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst)             count <= '0;
    else if (en) begin
      if (sum[CNT_W])    count <= '1;
      else               count <= sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/xrx_ctrl_monitor.sv
`timescale 1ns/1ps
module xrx_ctrl_monitor
  import xrx_chk_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int SFD_OFFSET = 7,
  parameter int CNT_W      = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [8*LANES-1:0] rx_data,
  input  logic [LANES-1:0]   rx_ctrl,
  output logic [CNT_W-1:0]   sym_err_count,
  output logic [CNT_W-1:0]   data_err_count,
  output logic [CNT_W-1:0]   ctrl_err_count
);
  localparam int LW     = $clog2(LANES);
  localparam int INC_W  = $clog2(2*LANES + 2);
  localparam int N_CNT  = 3;

  lane_info_t [LANES-1:0] info;
  logic                   in_frame_q, seen_err_q, sfd_pend_q;
  logic [LW-1:0]          sfd_lane_q;
  logic                   in_frame_d, seen_err_d, sfd_pend_d;
  logic [LW-1:0]          sfd_lane_d;
  logic [N_CNT-1:0][INC_W-1:0] incs;
  logic [N_CNT-1:0][CNT_W-1:0] counts;

  xrx_lane_decode #(.LANES(LANES)) u_dec (
    .rx_data (rx_data),
    .rx_ctrl (rx_ctrl),
    .info    (info)
  );

  xrx_frame_scan #(.LANES(LANES), .SFD_OFFSET(SFD_OFFSET), .INC_W(INC_W)) u_scan (
    .info       (info),
    .in_frame_q (in_frame_q),
    .seen_err_q (seen_err_q),
    .sfd_pend_q (sfd_pend_q),
    .sfd_lane_q (sfd_lane_q),
    .in_frame_d (in_frame_d),
    .seen_err_d (seen_err_d),
    .sfd_pend_d (sfd_pend_d),
    .sfd_lane_d (sfd_lane_d),
    .sym_inc    (incs[0]),
    .data_inc   (incs[1]),
    .ctrl_inc   (incs[2])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      seen_err_q <= 1'b0;
      sfd_pend_q <= 1'b0;
      sfd_lane_q <= '0;
    end else if (in_valid) begin
      in_frame_q <= in_frame_d;
      seen_err_q <= seen_err_d;
      sfd_pend_q <= sfd_pend_d;
      sfd_lane_q <= sfd_lane_d;
    end
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    xrx_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .en    (in_valid),
      .inc   (incs[g]),
      .count (counts[g])
    );
  end

  assign sym_err_count  = counts[0];
  assign data_err_count = counts[1];
  assign ctrl_err_count = counts[2];
endmodule

// File: rtl/xrx_ctrl_check.sv
`timescale 1ns/1ps
module xrx_ctrl_check #(
  parameter int LANES = 8,
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [LANES-1:0] rx_ctrl,
  input logic             sfd_pend,
  input logic [CNT_W-1:0] sym_cnt,
  input logic [CNT_W-1:0] dat_cnt,
  input logic [CNT_W-1:0] ctl_cnt
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (sym_cnt == '0 && dat_cnt == '0 && ctl_cnt == '0));

  assert_quiet_word_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(in_valid) && $past(rx_ctrl) == '0 && !$past(sfd_pend))
      |-> ($stable(sym_cnt) && $stable(dat_cnt) && $stable(ctl_cnt)));

  assert_monotonic_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(rst) |-> (sym_cnt >= $past(sym_cnt) && dat_cnt >= $past(dat_cnt)
                     && ctl_cnt >= $past(ctl_cnt)));

  assert_hold_invalid_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && !$past(in_valid))
      |-> ($stable(sym_cnt) && $stable(dat_cnt) && $stable(ctl_cnt)));

  assert_saturate_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(ctl_cnt) == '1) |-> (ctl_cnt == '1));

  assert_sym_bound_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(sym_cnt) != '1) |-> (sym_cnt - $past(sym_cnt) <= CNT_W'(3)));
endmodule

bind xrx_ctrl_monitor xrx_ctrl_check #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .rx_ctrl  (rx_ctrl),
  .sfd_pend (sfd_pend_q),
  .sym_cnt  (sym_err_count),
  .dat_cnt  (data_err_count),
  .ctl_cnt  (ctrl_err_count)
);

// File: tb/xrx_ctrl_monitor_test.sv
`timescale 1ns/1ps
module xrx_ctrl_monitor_test;
  localparam int CW = 8;
  localparam int MAXV = (1 << CW) - 1;
  localparam logic [7:0] KI = 8'h07, KS = 8'hFB, KT = 8'hFD, KE = 8'hFE;
  localparam logic [7:0] KX = 8'h9C, SF = 8'hD5, PD = 8'h55;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [63:0]   rx_data = '0;
  logic [7:0]    rx_ctrl = '0;
  logic [CW-1:0] sym_c, dat_c, ctl_c;

  int checks = 0, failures = 0;
  int m_sym = 0, m_dat = 0, m_ctl = 0;
  bit m_inf = 0, m_seen = 0, m_pend = 0;
  int m_plane = 0;

  always #5 clk = ~clk;

  xrx_ctrl_monitor #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
    .sym_err_count(sym_c), .data_err_count(dat_c), .ctrl_err_count(ctl_c)
  );

  function automatic logic [63:0] pk(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    return {b7, b6, b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  // Behavioural model of one accepted word.
  task automatic model_word(input logic [63:0] d, input logic [7:0] c);
    int s = 0, de = 0, ce = 0;
    logic [7:0] b;
    if (m_pend) begin
      if (c[m_plane] || d[8*m_plane +: 8] != SF) de++;
      m_pend = 0;
    end
    for (int ln = 0; ln < 8; ln++) begin
      b = d[8*ln +: 8];
      if (c[ln]) begin
        if (b == KS) begin
          if (ln == 0 || ln == 4) begin
            if (m_inf) de++;
            m_inf = 1; m_seen = 0;
            if (ln == 0) begin
              if (c[7] || d[63:56] != SF) de++;
            end else begin
              m_pend = 1; m_plane = 3;
            end
          end else begin
            de++; m_inf = 0;
          end
        end else if (b == KT) begin
          if (m_inf) m_inf = 0; else ce++;
        end else if (b == KE) begin
          if (m_inf) begin
            if (!m_seen) begin s++; m_seen = 1; end
          end else ce++;
        end else if (b == KI) begin
          if (m_inf) begin de++; m_inf = 0; end
        end else begin
          if (m_inf) de++; else ce++;
        end
      end
    end
    m_sym = sat(m_sym + s); m_dat = sat(m_dat + de); m_ctl = sat(m_ctl + ce);
  endtask

  task automatic compare(input string req);
    checks++;
    if (int'(sym_c) != m_sym || int'(dat_c) != m_dat || int'(ctl_c) != m_ctl) begin
      failures++;
      $display("FAIL %s: sym/data/ctrl actual %0d/%0d/%0d expected %0d/%0d/%0d",
               req, sym_c, dat_c, ctl_c, m_sym, m_dat, m_ctl);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input logic v, input logic [63:0] d, input logic [7:0] c, input string req);
    in_valid = v; rx_data = d; rx_ctrl = c;
    if (v) model_word(d, c);
    @(negedge clk);
    compare(req);
  endtask

  task automatic expect_val(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [63:0] w_idle, w_s0, w_s0bad, w_dat, w_t1, w_s4, w_s4n, w_s4nbad, w_s2, w_err2,
               w_eterm, w_unk, w_outmix, w_allt, w_tfirst;

  initial begin
    w_idle   = pk(KI, KI, KI, KI, KI, KI, KI, KI);
    w_s0     = pk(KS, PD, PD, PD, PD, PD, PD, SF);
    w_s0bad  = pk(KS, PD, PD, PD, PD, PD, PD, PD);
    w_dat    = {8{8'hA5}};
    w_t1     = pk(8'h11, KT, KI, KI, KI, KI, KI, KI);
    w_s4     = pk(KI, KI, KI, KI, KS, PD, PD, PD);
    w_s4n    = pk(PD, PD, PD, SF, 8'h22, 8'h23, 8'h24, 8'h25);
    w_s4nbad = pk(PD, PD, PD, PD, 8'h22, 8'h23, 8'h24, 8'h25);
    w_s2     = pk(KI, KI, KS, PD, PD, PD, PD, PD);
    w_err2   = pk(8'h01, 8'h02, 8'h03, KE, 8'h05, KE, 8'h07, 8'h08);
    w_eterm  = pk(KE, KT, KI, KI, KI, KI, KI, KI);
    w_unk    = pk(8'h01, KX, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08);
    w_outmix = pk(KT, KI, KE, KI, KX, KI, KI, KI);
    w_allt   = {8{KT}};
    w_tfirst = pk(KT, KE, KI, KI, KI, KI, KI, KI);

    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state");
    expect_val(int'(sym_c) + int'(dat_c) + int'(ctl_c), 0, "R1 counters zero");

    step(1, w_idle, 8'hFF, "R11 idle words");
    step(1, w_idle, 8'hFF, "R11 idle words");
    // Clean lane-0 frame
    step(1, w_s0, 8'h01, "R3 lane0 start good delimiter");
    step(1, w_dat, 8'h00, "R3 payload");
    step(1, w_t1, 8'hFE, "R3 terminate");
    // Clean lane-4 frame
    step(1, w_s4, 8'h1F, "R3 lane4 start");
    step(1, w_s4n, 8'h00, "R3 lane4 delimiter next word");
    step(1, w_t1, 8'hFE, "R3 terminate");
    expect_val(int'(dat_c), 0, "R3 clean frames no data error");
    // Bad delimiters
    step(1, w_s0bad, 8'h01, "R3 lane0 bad delimiter");
    step(1, w_t1, 8'hFE, "R3 terminate");
    step(1, w_s4, 8'h1F, "R3 lane4 start");
    step(1, w_s4nbad, 8'h00, "R3 lane4 bad delimiter");
    step(1, w_t1, 8'hFE, "R3 terminate");
    expect_val(int'(dat_c), 2, "R3 two bad delimiters");
    // Misplaced Start
    step(1, w_s2, 8'h07, "R2 start in lane 2");
    step(1, w_idle, 8'hFF, "R2 idle after");
    // Error symbols, once per frame
    step(1, w_s0, 8'h01, "R6 frame open");
    step(1, w_err2, 8'h28, "R6 two errors one frame");
    step(1, w_eterm, 8'hFF, "R6 error in terminate word");
    expect_val(int'(sym_c), 1, "R6 once per frame");
    // Restart inside a frame
    step(1, w_s0, 8'h01, "R4 frame open");
    step(1, w_err2, 8'h28, "R4 error first frame");
    step(1, w_s0, 8'h01, "R4 start inside frame");
    step(1, w_err2, 8'h28, "R4 error counted for new frame");
    step(1, w_t1, 8'hFE, "R4 terminate");
    // Idle and unknown inside frame
    step(1, w_s0, 8'h01, "R5 frame open");
    step(1, w_unk, 8'h02, "R5 unknown code inside frame");
    step(1, w_idle, 8'hFF, "R5 idle inside frame closes it");
    step(1, w_t1, 8'hFE, "R5 terminate now outside frame");
    // Outside-frame control characters
    step(1, w_outmix, 8'hFF, "R7 stray controls");
    step(1, w_dat, 8'h00, "R7 data outside frame");
    // Multiple events in one word
    step(1, w_allt, 8'hFF, "R8 eight terminates one word");
    // Lane order
    step(1, w_s0, 8'h01, "R11 frame open");
    step(1, w_tfirst, 8'hFF, "R11 terminate then error lane order");
    // Invalid cycles hold state
    step(1, w_s4, 8'h1F, "R9 lane4 start");
    step(0, w_allt, 8'hFF, "R9 invalid garbage");
    step(0, w_s4nbad, 8'h00, "R9 invalid bad delimiter");
    step(1, w_s4n, 8'h00, "R9 delimiter after gap");
    step(0, w_err2, 8'h28, "R9 invalid error word");
    step(1, w_err2, 8'h28, "R9 error after gap");
    step(1, w_t1, 8'hFE, "R9 terminate");
    // Saturation
    for (int k = 0; k < 40; k++) step(1, w_allt, 8'hFF, "R10 fill control counter");
    expect_val(int'(ctl_c), MAXV, "R10 saturated");
    step(1, w_outmix, 8'hFF, "R10 stays saturated");
    expect_val(int'(ctl_c), MAXV, "R10 still saturated");
    // Reset again
    rst = 1'b1; in_valid = 1'b0;
    m_sym = 0; m_dat = 0; m_ctl = 0; m_inf = 0; m_seen = 0; m_pend = 0;
    @(negedge clk);
    rst = 1'b0;
    compare("R1 second reset");
    step(1, w_tfirst, 8'hFF, "R1 outside frame after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule